// File: doc/BRIEF.md
# Command-Refreshed Watchdog Timer

This block is a watchdog counter that a host keeps alive through a serial command interface. The serial receiver is outside the block. It hands over each received word as a one-cycle strobe together with a length-check result, the 5-bit register address, the watchdog bit carried in that word, and the 2-bit period field. The host refreshes the watchdog by flipping the watchdog bit from one accepted word to the next. Repeating the same value does not refresh it. Any accepted word can carry such a flip, whatever register it addresses.

Time is counted in units of an external one-cycle millisecond tick. When the count reaches the terminal value of the active period, a timeout flag rises. The flag stays high until the next flip of the watchdog bit.

The period field is written only through the period register. A newly written period becomes active only when a fresh count begins. A host that wants the change to apply at once flips the watchdog bit in the same word that writes the period.

Top module: `wdt_cmd_timer`

## Requirements
- R1: The period codes map to terminal counts in ticks as follows: 2'b01 gives 310, 2'b00 gives 620, 2'b11 gives 1250 and 2'b10 gives 2500.
- R2: An accepted word whose address satisfies addr[3:0] == 4'b1101 writes cmd_sel into the pending period. Address bit 4 is ignored for this match.
- R3: An accepted word of any address whose cmd_wd_bit differs from the stored bit of the last accepted word restarts the count: the count returns to zero, timeout clears, and the stored bit takes the new value.
- R4: The active period is loaded only on a restart. A period write that carries a flip applies to the count that starts in that same cycle. A period write without a flip leaves the running period unchanged until the next flip.
- R5: A word at a no-operation address (addr[2:0] == 3'b110) never changes the pending period, whatever its cmd_sel holds. A flip carried in such a word still restarts the count.
- R6: A strobe with cmd_ok low has no effect on the count, the stored watchdog bit or the pending period, exactly as if no strobe had been given.
- R7: Each ms_tick advances the count by one. timeout goes high at the clock edge where the count reaches the active terminal value. After that, further ticks and non-flipping words leave it high.
- R8: Synchronous reset sets the count to zero, clears timeout, sets the stored watchdog bit to 0, and sets both the pending and the active period to code 2'b00.
- R9: When a restart and a tick fall in the same cycle, the restart wins and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_stb | input | 1 | One-cycle strobe: a complete command word has arrived |
| cmd_ok | input | 1 | The word passed the length check; if low, the strobe is ignored |
| cmd_addr | input | 5 | Register address of the word |
| cmd_wd_bit | input | 1 | Watchdog bit of the word |
| cmd_sel | input | 2 | Period field of the word |
| ms_tick | input | 1 | One-cycle millisecond tick |
| timeout | output | 1 | Watchdog expired; held until the next flip |

## Verification
The hardest case to reach from the ports is a pending period that differs from the period actually running. The only evidence of that difference is the exact tick on which the flag rises. The stimulus first writes a new period without a flip and checks that the flag still rises on the old boundary. It then flips the bit through a no-operation word and counts to one tick before the new boundary. Rejected strobes that carry both a flip and a period write are placed before such a restart. If either of those strobes had leaked into the state, the restart would be lost or the boundary would move.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_SEL_MID   = 2'b00,
        WD_SEL_SHORT = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_HALF  = 2'b11
    } wd_sel_e;

    // Terminal counts in millisecond ticks, indexed by period code.
    localparam int unsigned WD_TICKS_MID   = 620;
    localparam int unsigned WD_TICKS_SHORT = 310;
    localparam int unsigned WD_TICKS_LONG  = 2500;
    localparam int unsigned WD_TICKS_HALF  = 1250;

    // Address matches: only bits set in the mask are compared.
    localparam logic [4:0] WD_PER_ADDR = 5'b01101;
    localparam logic [4:0] WD_PER_MASK = 5'b01111;

    typedef struct packed {
        logic    restart;
        logic    sel_wr;
        wd_sel_e sel_val;
    } wd_cmd_s;

    function automatic int unsigned wd_max4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdt_cmd_decode.sv
module wdt_cmd_decode
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(WD_PER_ADDR),
    parameter logic [ADDR_W-1:0] PER_MASK = ADDR_W'(WD_PER_MASK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wd_bit,
    input  logic [1:0]        sel,
    output wd_cmd_s           cmd,
    output logic              last_bit
);

    logic accepted;

    assign accepted    = stb && ok;
    assign cmd.restart = accepted && (wd_bit != last_bit);
    assign cmd.sel_wr  = accepted && ((addr & PER_MASK) == (PER_ADDR & PER_MASK));
    assign cmd.sel_val = wd_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_bit <= 1'b0;
        end else if (cmd.restart) begin
            last_bit <= wd_bit;
        end
    end

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_cmd_s cmd,
    output wd_sel_e pending,
    output wd_sel_e active
);

    wd_sel_e next_pending;

    always_comb begin
        next_pending = pending;
        if (cmd.sel_wr) begin
            next_pending = cmd.sel_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= WD_SEL_MID;
            active  <= WD_SEL_MID;
        end else begin
            pending <= next_pending;
            if (cmd.restart) begin
                active <= next_pending;
            end
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int unsigned T_MID   = WD_TICKS_MID,
    parameter int unsigned T_SHORT = WD_TICKS_SHORT,
    parameter int unsigned T_LONG  = WD_TICKS_LONG,
    parameter int unsigned T_HALF  = WD_TICKS_HALF,
    parameter int unsigned CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  wd_sel_e          active,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] term,
    output logic             expired
);

    logic [CNT_W-1:0] count_inc;

    always_comb begin
        unique case (active)
            WD_SEL_MID:   term = CNT_W'(T_MID);
            WD_SEL_SHORT: term = CNT_W'(T_SHORT);
            WD_SEL_LONG:  term = CNT_W'(T_LONG);
            WD_SEL_HALF:  term = CNT_W'(T_HALF);
            default:      term = CNT_W'(T_MID);
        endcase
    end

    assign count_inc = count + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (restart) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            count <= count_inc;
            if (count_inc == term) begin
                expired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_cmd_timer.sv
module wdt_cmd_timer
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned T_MID   = WD_TICKS_MID,
    parameter int unsigned T_SHORT = WD_TICKS_SHORT,
    parameter int unsigned T_LONG  = WD_TICKS_LONG,
    parameter int unsigned T_HALF  = WD_TICKS_HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic              cmd_ok,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wd_bit,
    input  logic [1:0]        cmd_sel,
    input  logic              ms_tick,
    output logic              timeout
);

    localparam int unsigned T_MAX = wd_max4(T_MID, T_SHORT, T_LONG, T_HALF);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    wd_cmd_s          cmd;
    logic             last_bit;
    wd_sel_e          pending;
    wd_sel_e          active;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] term;

    wdt_cmd_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .stb      (cmd_stb),
        .ok       (cmd_ok),
        .addr     (cmd_addr),
        .wd_bit   (cmd_wd_bit),
        .sel      (cmd_sel),
        .cmd      (cmd),
        .last_bit (last_bit)
    );

    wdt_period_sel u_period (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .pending (pending),
        .active  (active)
    );

    wdt_tick_counter #(
        .T_MID   (T_MID),
        .T_SHORT (T_SHORT),
        .T_LONG  (T_LONG),
        .T_HALF  (T_HALF),
        .CNT_W   (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd.restart),
        .tick    (ms_tick),
        .active  (active),
        .count   (count),
        .term    (term),
        .expired (timeout)
    );

endmodule

// File: rtl/wdt_cmd_timer_chk.sv
module wdt_cmd_timer_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_stb,
    input logic              cmd_ok,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              ms_tick,
    input logic              restart,
    input logic              sel_wr,
    input logic              last_bit,
    input logic [1:0]        pending,
    input logic [1:0]        active,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  term,
    input logic              timeout
);

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count == '0 && !timeout));

    p_adopt_r4: assert property (@(posedge clk) disable iff (rst)
        (restart && !sel_wr) |=> active == $past(pending));

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(active));

    p_nop_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_ok && cmd_addr[2:0] == 3'b110) |=> $stable(pending));

    p_reject_r6: assert property (@(posedge clk) disable iff (rst)
        !(cmd_stb && cmd_ok) |=> ($stable(last_bit) && $stable(pending)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (timeout && !restart) |=> timeout);

    p_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= term);

    p_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> count == term);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (count == '0 && !timeout && !last_bit && active == 2'b00 && pending == 2'b00));

    p_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (restart && ms_tick) |=> count == '0);

endmodule

bind wdt_cmd_timer wdt_cmd_timer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_stb  (cmd_stb),
    .cmd_ok   (cmd_ok),
    .cmd_addr (cmd_addr),
    .ms_tick  (ms_tick),
    .restart  (cmd.restart),
    .sel_wr   (cmd.sel_wr),
    .last_bit (last_bit),
    .pending  (pending),
    .active   (active),
    .count    (count),
    .term     (term),
    .timeout  (timeout)
);

// File: tb/wdt_cmd_timer_test.sv
`timescale 1ns/1ps
module wdt_cmd_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_stb = 1'b0;
    logic       cmd_ok = 1'b0;
    logic [4:0] cmd_addr = '0;
    logic       cmd_wd_bit = 1'b0;
    logic [1:0] cmd_sel = '0;
    logic       ms_tick = 1'b0;
    logic       timeout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_cmd_timer uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_stb    (cmd_stb),
        .cmd_ok     (cmd_ok),
        .cmd_addr   (cmd_addr),
        .cmd_wd_bit (cmd_wd_bit),
        .cmd_sel    (cmd_sel),
        .ms_tick    (ms_tick),
        .timeout    (timeout)
    );

    // Vector: {ok, addr[4:0], wd_bit, sel[1:0], ticks[15:0], expected timeout}
    localparam int NV = 14;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 5'b01101, 1'b1, 2'b01, 16'd309,  1'b0}, // R1 R2 R4: flip + period 310
        {1'b1, 5'b00110, 1'b1, 2'b00, 16'd1,    1'b1}, // R1: 310 boundary
        {1'b1, 5'b00110, 1'b0, 2'b11, 16'd309,  1'b0}, // R5: no-op flip, sel ignored
        {1'b1, 5'b11101, 1'b0, 2'b10, 16'd1,    1'b1}, // R4 R2: write w/o flip, old period
        {1'b1, 5'b00110, 1'b1, 2'b00, 16'd2499, 1'b0}, // R4 R1: 2500 now active
        {1'b0, 5'b00110, 1'b0, 2'b00, 16'd1,    1'b1}, // R6: rejected flip
        {1'b0, 5'b01101, 1'b0, 2'b01, 16'd0,    1'b1}, // R6: rejected period write
        {1'b1, 5'b00110, 1'b0, 2'b00, 16'd310,  1'b0}, // R6: still 2500 pending
        {1'b1, 5'b01101, 1'b1, 2'b11, 16'd1249, 1'b0}, // R1: 1250
        {1'b1, 5'b00011, 1'b1, 2'b00, 16'd1,    1'b1}, // R7: 1250 boundary
        {1'b1, 5'b00011, 1'b0, 2'b10, 16'd1249, 1'b0}, // R3: flip from other address
        {1'b1, 5'b10110, 1'b0, 2'b00, 16'd1,    1'b1}, // R3: period kept at 1250
        {1'b1, 5'b01101, 1'b1, 2'b00, 16'd619,  1'b0}, // R1: 620
        {1'b1, 5'b00110, 1'b1, 2'b00, 16'd1,    1'b1}  // R1: 620 boundary
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (timeout !== exp) begin
            errors++;
            $display("FAIL %s: timeout actual %b expected %b", req, timeout, exp);
        end
    endtask

    task automatic send(input logic ok, input logic [4:0] addr, input logic wd,
                        input logic [1:0] sel, input logic tick);
        cmd_stb    = 1'b1;
        cmd_ok     = ok;
        cmd_addr   = addr;
        cmd_wd_bit = wd;
        cmd_sel    = sel;
        ms_tick    = tick;
        @(negedge clk);
        cmd_stb = 1'b0;
        cmd_ok  = 1'b0;
        ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(1'b0, "R8 reset clears timeout");
        ticks(619);
        check(1'b0, "R8 default 620 below boundary");
        ticks(1);
        check(1'b1, "R8 default 620 at boundary");

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][25], VEC[v][24:20], VEC[v][19], VEC[v][18:17], 1'b0);
            ticks(int'(VEC[v][16:1]));
            check(VEC[v][0], $sformatf("R1-table vector %0d", v));
        end

        // R8: reset in the middle of an expired state
        do_reset();
        check(1'b0, "R8 reset after expiry");

        // R8: stored bit is 0 after reset, so a zero bit does not restart
        ticks(300);
        send(1'b1, 5'b00110, 1'b0, 2'b00, 1'b0);
        ticks(320);
        check(1'b1, "R8 stored bit 0, no restart");

        // R9: flip and tick in the same cycle; restart wins
        send(1'b1, 5'b00110, 1'b1, 2'b00, 1'b1);
        ticks(619);
        check(1'b0, "R9 restart beats tick");
        ticks(1);
        check(1'b1, "R9 boundary after restart");

        // R7: flag held through ticks and non-flipping words
        ticks(50);
        send(1'b1, 5'b01101, 1'b1, 2'b01, 1'b1);
        check(1'b1, "R7 flag held");

        // R4 R2: period write without flip, then flip applies 310
        send(1'b1, 5'b00110, 1'b0, 2'b00, 1'b0);
        ticks(309);
        check(1'b0, "R4 pending 310 adopted at flip");
        ticks(1);
        check(1'b1, "R4 310 boundary");

        finish_run();
    end

endmodule